// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This combinational unit decides where each of the two ALU operands comes from in a five-stage integer pipeline. It looks at the instruction waiting to execute and at the two older instructions further down the pipe. When an older instruction will write a register that the waiting instruction reads, the unit passes the newer value forward instead of the stale register-file value. It outputs the two selected operand values and a select code for each operand.

Instruction words are 32 bits wide. In this note bit positions are written in little-endian form: `[31:26]` is the opcode and `[25:21]`, `[20:16]` and `[15:11]` are the three register fields. The unit does not stall loads and does not write the register file. Other logic handles those tasks.

Top module: `alu_operand_forward`

## Requirements
- R1: Opcode classes are: `6'h00` register-register ALU; `[31:29]==3'b001` ALU-immediate; `[31:29]==3'b100` load; `[31:29]==3'b101` store; `[31:28]==4'b0001` branch. Every other opcode is "other". The first operand source is `[25:21]`, and it is forwarded only for register-register, immediate, load, store and branch consumers. An "other" consumer always reads the register file.
- R2: A valid register-register producer writes the register in `[15:11]`. Its result is forwarded when that field equals a consumer source field.
- R3: A valid ALU-immediate or load producer writes the register in `[20:16]`. Its `[15:11]` bits play no part in forwarding.
- R4: The second operand (source `[20:16]`) is forwarded only when the consumer is register-register. For any other consumer `sel_bottom` is 0.
- R5: If both EX/MEM and MEM/WB match a source, EX/MEM wins (select 1).
- R6: A load in MEM/WB forwards `memwb_load`. A load in EX/MEM never forwards, so a matching MEM/WB producer or the register file is used instead.
- R7: A matching destination of register 0 never forwards.
- R8: A producer whose valid bit is low never forwards. Store, branch and other producers never forward. With both valid bits low, both selects are 0.
- R9: With no match, the select is 0 and the operand equals the register-file value.
- R10: The select codes are 0 for register file, 1 for EX/MEM ALU result and 2 for MEM/WB result. Code 3 never appears. Each operand equals the source its select names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_insn | input | 32 | Instruction about to execute (consumer) |
| exmem_insn | input | 32 | Instruction in EX/MEM |
| exmem_valid | input | 1 | EX/MEM holds a real instruction |
| exmem_alu | input | 32 | ALU result held in EX/MEM |
| memwb_insn | input | 32 | Instruction in MEM/WB |
| memwb_valid | input | 1 | MEM/WB holds a real instruction |
| memwb_alu | input | 32 | ALU result held in MEM/WB |
| memwb_load | input | 32 | Load data held in MEM/WB |
| rf_top | input | 32 | Register-file value for the first operand |
| rf_bottom | input | 32 | Register-file value for the second operand |
| sel_top | output | 2 | First operand source code |
| sel_bottom | output | 2 | Second operand source code |
| opnd_top | output | 32 | First ALU operand |
| opnd_bottom | output | 32 | Second ALU operand |

## Verification
The hardest case to produce is a match that must be refused. Examples are a load in EX/MEM whose destination hits a source while an older ALU result in MEM/WB also hits it, and an immediate producer whose `[15:11]` bits happen to spell a register the consumer reads.

The stimulus builds these instruction words on purpose. It sets the refused producer's fields to the very register the consumer reads, then checks that the fall-through source (MEM/WB or the register file) is chosen. Each source carries a distinct data pattern, so a wrong choice shows in the operand values as well as in the select.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 6;

  typedef enum logic [2:0] {
    CL_RR, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_OTHER
  } insn_class_e;

  typedef enum logic [1:0] {
    SEL_RF = 2'd0, SEL_EXMEM = 2'd1, SEL_MEMWB = 2'd2
  } opnd_sel_e;

  function automatic insn_class_e classify(input logic [OP_W-1:0] op);
    if (op == '0)                 return CL_RR;
    else if (op[5:3] == 3'b001)   return CL_IMM;
    else if (op[5:3] == 3'b100)   return CL_LOAD;
    else if (op[5:3] == 3'b101)   return CL_STORE;
    else if (op[5:2] == 4'b0001)  return CL_BRANCH;
    else                          return CL_OTHER;
  endfunction
endpackage

// File: rtl/fwd_producer.sv
module fwd_producer
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             valid,
  input  logic [OP_W-1:0]  op,
  input  logic [REG_W-1:0] fld_mid,
  input  logic [REG_W-1:0] fld_low,
  output logic             wr_en,
  output logic             is_load,
  output logic [REG_W-1:0] dst
);
  insn_class_e cls;

  always_comb begin
    cls     = classify(op);
    is_load = (cls == CL_LOAD);
    dst     = (cls == CL_RR) ? fld_low : fld_mid;
    wr_en   = valid && (dst != '0) &&
              (cls == CL_RR || cls == CL_IMM || cls == CL_LOAD);
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [REG_W-1:0]  src,
  input  logic              elig,
  input  logic              ex_wr,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic [DATA_W-1:0] ex_data,
  input  logic              mw_wr,
  input  logic [REG_W-1:0]  mw_dst,
  input  logic [DATA_W-1:0] mw_data,
  input  logic [DATA_W-1:0] rf_data,
  output logic [1:0]        sel,
  output logic [DATA_W-1:0] opnd
);
  logic ex_hit, mw_hit;

  always_comb begin
    ex_hit = elig && ex_wr && (ex_dst == src);
    mw_hit = elig && mw_wr && (mw_dst == src);
    if (ex_hit) begin
      sel  = SEL_EXMEM;
      opnd = ex_data;
    end else if (mw_hit) begin
      sel  = SEL_MEMWB;
      opnd = mw_data;
    end else begin
      sel  = SEL_RF;
      opnd = rf_data;
    end
  end
endmodule

// File: rtl/alu_operand_forward.sv
module alu_operand_forward
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [INSN_W-1:0] idex_insn,
  input  logic [INSN_W-1:0] exmem_insn,
  input  logic              exmem_valid,
  input  logic [DATA_W-1:0] exmem_alu,
  input  logic [INSN_W-1:0] memwb_insn,
  input  logic              memwb_valid,
  input  logic [DATA_W-1:0] memwb_alu,
  input  logic [DATA_W-1:0] memwb_load,
  input  logic [DATA_W-1:0] rf_top,
  input  logic [DATA_W-1:0] rf_bottom,
  output logic [1:0]        sel_top,
  output logic [1:0]        sel_bottom,
  output logic [DATA_W-1:0] opnd_top,
  output logic [DATA_W-1:0] opnd_bottom
);
  localparam int OP_LSB   = INSN_W - OP_W;
  localparam int HI_LSB   = OP_LSB - REG_W;
  localparam int MID_LSB  = HI_LSB - REG_W;
  localparam int LOW_LSB  = MID_LSB - REG_W;
  localparam int N_OPND   = 2;

  logic             ex_wr, ex_ld, mw_wr, mw_ld, ex_wr_alu;
  logic [REG_W-1:0] ex_dst, mw_dst;
  logic [DATA_W-1:0] mw_data;
  insn_class_e      id_cls;

  logic [REG_W-1:0]  src_v  [N_OPND];
  logic              elig_v [N_OPND];
  logic [DATA_W-1:0] rf_v   [N_OPND];
  logic [1:0]        sel_v  [N_OPND];
  logic [DATA_W-1:0] opnd_v [N_OPND];

  logic unused_bits;
  assign unused_bits = ^{idex_insn[MID_LSB-1:0], exmem_insn[OP_LSB-1:HI_LSB],
                         exmem_insn[LOW_LSB-1:0], memwb_insn[OP_LSB-1:HI_LSB],
                         memwb_insn[LOW_LSB-1:0]};

  fwd_producer #(.REG_W(REG_W)) u_ex_prod (
    .valid   (exmem_valid),
    .op      (exmem_insn[INSN_W-1:OP_LSB]),
    .fld_mid (exmem_insn[HI_LSB-1:MID_LSB]),
    .fld_low (exmem_insn[MID_LSB-1:LOW_LSB]),
    .wr_en   (ex_wr),
    .is_load (ex_ld),
    .dst     (ex_dst)
  );

  fwd_producer #(.REG_W(REG_W)) u_mw_prod (
    .valid   (memwb_valid),
    .op      (memwb_insn[INSN_W-1:OP_LSB]),
    .fld_mid (memwb_insn[HI_LSB-1:MID_LSB]),
    .fld_low (memwb_insn[MID_LSB-1:LOW_LSB]),
    .wr_en   (mw_wr),
    .is_load (mw_ld),
    .dst     (mw_dst)
  );

  always_comb begin
    ex_wr_alu = ex_wr && !ex_ld;
    mw_data   = mw_ld ? memwb_load : memwb_alu;
    id_cls    = classify(idex_insn[INSN_W-1:OP_LSB]);
    src_v[0]  = idex_insn[OP_LSB-1:HI_LSB];
    src_v[1]  = idex_insn[HI_LSB-1:MID_LSB];
    elig_v[0] = (id_cls != CL_OTHER);
    elig_v[1] = (id_cls == CL_RR);
    rf_v[0]   = rf_top;
    rf_v[1]   = rf_bottom;
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_operand_mux #(.DATA_W(DATA_W), .REG_W(REG_W)) u_mux (
      .src     (src_v[g]),
      .elig    (elig_v[g]),
      .ex_wr   (ex_wr_alu),
      .ex_dst  (ex_dst),
      .ex_data (exmem_alu),
      .mw_wr   (mw_wr),
      .mw_dst  (mw_dst),
      .mw_data (mw_data),
      .rf_data (rf_v[g]),
      .sel     (sel_v[g]),
      .opnd    (opnd_v[g])
    );
  end

  assign sel_top     = sel_v[0];
  assign sel_bottom  = sel_v[1];
  assign opnd_top    = opnd_v[0];
  assign opnd_bottom = opnd_v[1];
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [5:0]        id_op,
  input logic [REG_W-1:0]  id_rs1,
  input logic [REG_W-1:0]  id_rs2,
  input logic [5:0]        ex_op,
  input logic              exmem_valid,
  input logic              memwb_valid,
  input logic [DATA_W-1:0] exmem_alu,
  input logic [DATA_W-1:0] rf_top,
  input logic [DATA_W-1:0] rf_bottom,
  input logic [1:0]        sel_top,
  input logic [1:0]        sel_bottom,
  input logic [DATA_W-1:0] opnd_top,
  input logic [DATA_W-1:0] opnd_bottom
);
  always_comb begin
    // R10
    sel_range_chk: assert (sel_top != 2'd3 && sel_bottom != 2'd3);
    // R4
    bottom_rr_only_chk: assert (sel_bottom == 2'd0 || id_op == 6'h00);
    // R7
    no_zero_src_chk: assert ((sel_top == 2'd0 || id_rs1 != '0) &&
                             (sel_bottom == 2'd0 || id_rs2 != '0));
    // R8
    bubble_chk: assert ((sel_top != 2'd1 || exmem_valid) &&
                        (sel_top != 2'd2 || memwb_valid) &&
                        (sel_bottom != 2'd1 || exmem_valid) &&
                        (sel_bottom != 2'd2 || memwb_valid));
    // R6
    no_ex_load_chk: assert ((sel_top != 2'd1 && sel_bottom != 2'd1) ||
                            ex_op[5:3] != 3'b100);
    // R9
    rf_pass_chk: assert ((sel_top != 2'd0 || opnd_top == rf_top) &&
                         (sel_bottom != 2'd0 || opnd_bottom == rf_bottom));
    // R10
    ex_data_chk: assert ((sel_top != 2'd1 || opnd_top == exmem_alu) &&
                         (sel_bottom != 2'd1 || opnd_bottom == exmem_alu));
  end
endmodule

bind alu_operand_forward fwd_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .id_op       (idex_insn[31:26]),
  .id_rs1      (idex_insn[25:21]),
  .id_rs2      (idex_insn[20:16]),
  .ex_op       (exmem_insn[31:26]),
  .exmem_valid (exmem_valid),
  .memwb_valid (memwb_valid),
  .exmem_alu   (exmem_alu),
  .rf_top      (rf_top),
  .rf_bottom   (rf_bottom),
  .sel_top     (sel_top),
  .sel_bottom  (sel_bottom),
  .opnd_top    (opnd_top),
  .opnd_bottom (opnd_bottom)
);

// File: tb/tb_alu_operand_forward.sv
module tb_alu_operand_forward;
  localparam logic [31:0] D_EX = 32'hAAAA0001, D_MWA = 32'hBBBB0002,
                          D_MWL = 32'hCCCC0003, D_RFT = 32'h11110004,
                          D_RFB = 32'h22220005;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] idex_insn, exmem_insn, memwb_insn;
  logic        exmem_valid, memwb_valid;
  logic [1:0]  sel_top, sel_bottom;
  logic [31:0] opnd_top, opnd_bottom;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]  st, sb;
    logic [31:0] dt, db;
    string       tag;
  } exp_t;
  exp_t q[$];

  alu_operand_forward dut (
    .idex_insn(idex_insn), .exmem_insn(exmem_insn), .exmem_valid(exmem_valid),
    .exmem_alu(D_EX), .memwb_insn(memwb_insn), .memwb_valid(memwb_valid),
    .memwb_alu(D_MWA), .memwb_load(D_MWL), .rf_top(D_RFT), .rf_bottom(D_RFB),
    .sel_top(sel_top), .sel_bottom(sel_bottom),
    .opnd_top(opnd_top), .opnd_bottom(opnd_bottom));

  function automatic logic [31:0] rr(input int a, input int b, input int d);
    return {6'h00, 5'(a), 5'(b), 5'(d), 11'h0};
  endfunction
  function automatic logic [31:0] imm(input int a, input int d, input logic [15:0] k);
    return {6'h08, 5'(a), 5'(d), k};
  endfunction
  function automatic logic [31:0] ld(input int a, input int d);
    return {6'h23, 5'(a), 5'(d), 16'h0};
  endfunction
  function automatic logic [31:0] st(input int a, input int b);
    return {6'h2B, 5'(a), 5'(b), 16'h0};
  endfunction
  function automatic logic [31:0] br(input int a);
    return {6'h04, 5'(a), 5'd0, 16'h0};
  endfunction

  function automatic logic [31:0] dsel(input logic [1:0] s, input bit mwl,
                                       input logic [31:0] rf);
    case (s)
      2'd1:    return D_EX;
      2'd2:    return mwl ? D_MWL : D_MWA;
      default: return rf;
    endcase
  endfunction

  task automatic drive(input logic [31:0] id, input logic [31:0] ex, input bit exv,
                       input logic [31:0] mw, input bit mwv, input bit mwl,
                       input logic [1:0] est, input logic [1:0] esb, input string tag);
    exp_t e;
    @(negedge clk);
    idex_insn = id; exmem_insn = ex; exmem_valid = exv;
    memwb_insn = mw; memwb_valid = mwv;
    e.st = est; e.sb = esb;
    e.dt = dsel(est, mwl, D_RFT); e.db = dsel(esb, mwl, D_RFB);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what,
                     input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp({30'd0, sel_top}, {30'd0, e.st}, "sel_top", e.tag);
      cmp({30'd0, sel_bottom}, {30'd0, e.sb}, "sel_bottom", e.tag);
      cmp(opnd_top, e.dt, "opnd_top", e.tag);
      cmp(opnd_bottom, e.db, "opnd_bottom", e.tag);
    end
  end

  initial begin
    idex_insn = '0; exmem_insn = '0; memwb_insn = '0;
    exmem_valid = 0; memwb_valid = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8: reset state, both bubbles although fields match
    drive(rr(1,2,3), rr(0,0,1), 0, rr(0,0,2), 0, 0, 0, 0, "R8 bubbles");
    // R2: RR producer in EX/MEM, [15:11]
    drive(rr(1,2,3), rr(4,5,1), 1, '0, 0, 0, 1, 0, "R2 ex top");
    drive(rr(1,2,3), rr(4,5,2), 1, '0, 0, 0, 0, 1, "R2 ex bottom");
    // R3: immediate producer, dest [20:16]; [15:11]=7 ignored
    drive(rr(5,5,3), imm(1,5,16'h3800), 1, '0, 0, 0, 1, 1, "R3 imm dest");
    drive(rr(7,7,3), imm(1,5,16'h3800), 1, '0, 0, 0, 0, 0, "R3 imm low field");
    // R4: immediate consumer never forwards bottom
    drive(imm(3,4,16'h0), rr(0,0,4), 1, rr(0,0,3), 1, 0, 2, 0, "R4 imm consumer");
    // R5: both stages match
    drive(rr(6,6,1), rr(0,0,6), 1, rr(0,0,6), 1, 0, 1, 1, "R5 priority");
    // R6: load in MEM/WB gives load data to a store consumer
    drive(st(8,8), '0, 0, ld(0,8), 1, 1, 2, 0, "R6 mw load");
    // R6: load in EX/MEM refused, MEM/WB ALU used
    drive(rr(8,9,1), ld(0,8), 1, rr(0,0,8), 1, 0, 2, 0, "R6 ex load");
    // R7: register 0
    drive(rr(0,0,1), rr(0,0,0), 1, imm(0,0,16'h0), 1, 0, 0, 0, "R7 zero");
    // R8: store and branch producers
    drive(rr(10,10,1), st(1,10), 1, {6'h04, 5'd1, 5'd10, 5'd10, 11'h0}, 1, 0, 0, 0,
          "R8 st br producers");
    // R1: branch consumer top from MEM/WB immediate
    drive(br(12), '0, 0, imm(0,12,16'h0), 1, 0, 2, 0, "R1 branch consumer");
    // R1: other-class consumer never forwards
    drive({6'h02, 5'd12, 5'd12, 16'h0}, rr(0,0,12), 1, '0, 0, 0, 0, 0, "R1 other");
    // R9: no match
    drive(rr(13,14,1), rr(0,0,15), 1, ld(0,16), 1, 1, 0, 0, "R9 no match");
    // R10: mixed sources on the two operands
    drive(rr(17,18,1), rr(0,0,18), 1, ld(0,17), 1, 1, 2, 1, "R10 mixed");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule